// File: doc/BRIEF.md
# Lockup Recovery Heartbeat Scheduler

This block decides when a management controller puts a status message on a side-band bus while the host processor is hung. It takes timeout pulses from an external watchdog, a hardware event strobe, a firmware strobe that clears the lockup status, and a flag that says whether the system is in its working power state. It issues a held send request with a 4-bit sequence number and a one-bit kind tag (event or heartbeat), a one-cycle processor-reboot request, and a sticky lockup status bit.

The first watchdog expiry in the working state latches the lockup status, queues one event message and asks for one processor reboot. Later expiries never ask for another reboot. The count of expiries saturates at three, which marks the reboot attempt as failed. While the status bit is set, a heartbeat message goes out every `HB_SECONDS` ticks of a one-second time base. That time base comes from a prescaler over `TICKS_PER_SEC` clock cycles. Heartbeats continue across soft-off, because firmware can clear the status only in the working state. Event messages advance the sequence number and heartbeats repeat it.

Top module: `hb_lockup_sched`

## Requirements
- R1: After reset, msgReq, rebootReq and lockupSts are low, and the sequence counter is 0, so the first event message carries sequence 1.
- R2: Each hwEvent strobe produces one message with msgKind = 1 (event). Its msgSeq is one more than the previous event's, wrapping from 15 to 0.
- R3: While lockupSts is high, a message with msgKind = 0 (heartbeat) is issued every HB_SECONDS*TICKS_PER_SEC cycles. The first is issued HB_SECONDS*TICKS_PER_SEC+1 cycles after the edge that set lockupSts. A heartbeat carries the last event sequence unchanged. No heartbeat is issued while lockupSts is low.
- R4: The first wdtExpire seen with pwrWorking high sets lockupSts, pulses rebootReq for exactly one cycle in the same cycle, and produces exactly one event message.
- R5: The second, third and later expiries before a clear produce no rebootReq and no event message. Heartbeats continue.
- R6: While pwrWorking is low, wdtExpire and stsClear have no effect on lockupSts or rebootReq. Heartbeats already running continue.
- R7: stsClear with pwrWorking high clears lockupSts, stops heartbeats and resets the expiry count, so the next expiry again behaves as in R4.
- R8: If an event falls due in the same cycle as a heartbeat, only the event message is sent, and the next heartbeat follows a full period later.
- R9: A request stays high with msgSeq and msgKind unchanged until msgAck is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wdtExpire | input | 1 | Watchdog timeout pulse |
| hwEvent | input | 1 | Hardware event strobe |
| stsClear | input | 1 | Firmware clear of the lockup status |
| pwrWorking | input | 1 | High when the system is in the working power state |
| msgAck | input | 1 | Bus side accepts the current request |
| msgReq | output | 1 | Message send request, held until acknowledged |
| msgSeq | output | SEQ_W | Sequence number of the requested message |
| msgKind | output | 1 | 1 = event message, 0 = heartbeat |
| rebootReq | output | 1 | One-cycle processor reboot request |
| lockupSts | output | 1 | Sticky lockup status bit |

## Verification
The bench builds the block with TICKS_PER_SEC = 4 and HB_SECONDS = 3, so a heartbeat period is 12 cycles. With such a short period, every heartbeat can be timed to the exact cycle, and an event can be placed on the very edge where a heartbeat falls due. The short period also lets a full sequence wrap, the saturating expiry count, a soft-off interval and a clear followed by a second lockup all fit in a few hundred cycles.

// File: rtl/hbsched_pkg.sv
package hbsched_pkg;

  typedef enum logic {
    KIND_HEARTBEAT = 1'b0,
    KIND_EVENT     = 1'b1
  } msgKind_e;

  // Strobes from the recovery control to the message datapath
  typedef struct packed {
    logic evtDue;     // an event message must be queued
    logic hbRun;      // heartbeat beaconing active
    logic hbRestart;  // lockup just began: restart the time base
  } ctrlStrobe_t;

endpackage

// File: rtl/hbs_recovery_ctrl.sv
module hbs_recovery_ctrl
  import hbsched_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wdtExpire,
  input  logic        hwEvent,
  input  logic        stsClear,
  input  logic        pwrWorking,
  output ctrlStrobe_t strb,
  output logic        rebootReq,
  output logic        lockupSts
);

  logic [1:0] wdCnt;
  logic       wdHit;
  logic       fwClr;
  logic       lockStart;

  assign wdHit     = wdtExpire && pwrWorking;
  assign fwClr     = stsClear && pwrWorking;
  assign lockStart = wdHit && !fwClr && (wdCnt == 2'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdCnt     <= 2'd0;
      lockupSts <= 1'b0;
      rebootReq <= 1'b0;
    end else begin
      rebootReq <= lockStart;
      if (fwClr) begin
        wdCnt     <= 2'd0;
        lockupSts <= 1'b0;
      end else if (wdHit && (wdCnt != 2'd3)) begin
        wdCnt <= wdCnt + 2'd1;
        if (lockStart) lockupSts <= 1'b1;
      end
    end
  end

  assign strb.evtDue    = hwEvent || lockStart;
  assign strb.hbRun     = lockupSts;
  assign strb.hbRestart = lockStart;

  // R4: a reboot request only accompanies a fresh lockup
  a_r4_reboot_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    rebootReq |-> (lockupSts && !$past(lockupSts)));

  // R5: once the expiry count has saturated, no further reboot
  a_r5_no_reboot_failed: assert property (@(posedge clk) disable iff (!rstN)
    (wdCnt == 2'd3 && !stsClear) |=> !rebootReq);

  // R6: outside the working state the status cannot move
  a_r6_frozen_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !pwrWorking |=> $stable(lockupSts));

endmodule

// File: rtl/hbs_msg_path.sv
module hbs_msg_path
  import hbsched_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 100_000_000,
  parameter int unsigned HB_SECONDS    = 31,
  parameter int unsigned SEQ_W         = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic             msgAck,
  output logic             msgReq,
  output logic [SEQ_W-1:0] msgSeq,
  output msgKind_e         msgKind
);

  localparam int unsigned PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int unsigned HB_W  = $clog2(HB_SECONDS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);
  localparam logic [HB_W-1:0]  HB_LOAD  = HB_W'(HB_SECONDS);

  logic [PRE_W-1:0] preCnt;
  logic [HB_W-1:0]  hbCnt;
  logic [SEQ_W-1:0] seqQ;
  logic             tick;
  logic             hbDue;
  logic             evtPend;
  logic             hbPend;
  logic             slotFree;
  logic             launchEvt;
  logic             launchHb;

  assign tick  = (preCnt == PRE_LAST);
  assign hbDue = strb.hbRun && !strb.hbRestart && tick && (hbCnt == HB_W'(1));

  // One-second prescaler and heartbeat countdown
  always_ff @(posedge clk) begin
    if (!rstN || strb.hbRestart || !strb.hbRun) begin
      preCnt <= '0;
      hbCnt  <= HB_LOAD;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) hbCnt <= (hbCnt == HB_W'(1)) ? HB_LOAD : hbCnt - 1'b1;
    end
  end

  assign slotFree  = !msgReq || msgAck;
  assign launchEvt = slotFree && evtPend;
  assign launchHb  = slotFree && !evtPend && hbPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtPend <= 1'b0;
      hbPend  <= 1'b0;
    end else begin
      evtPend <= (evtPend && !launchEvt) || strb.evtDue;
      hbPend  <= strb.hbRun && ((hbPend && !launchHb) || (hbDue && !strb.evtDue));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgReq  <= 1'b0;
      msgSeq  <= '0;
      msgKind <= KIND_HEARTBEAT;
      seqQ    <= '0;
    end else if (launchEvt) begin
      msgReq  <= 1'b1;
      msgKind <= KIND_EVENT;
      seqQ    <= seqQ + 1'b1;
      msgSeq  <= seqQ + 1'b1;
    end else if (launchHb) begin
      msgReq  <= 1'b1;
      msgKind <= KIND_HEARTBEAT;
      msgSeq  <= seqQ;
    end else if (slotFree) begin
      msgReq  <= 1'b0;
    end
  end

  // R9: an unacknowledged request is held unchanged
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (msgReq && !msgAck) |=> (msgReq && $stable(msgSeq) && $stable(msgKind)));

  // R2: the sequence only ever steps by one
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    (seqQ != $past(seqQ)) |-> (seqQ == SEQ_W'($past(seqQ) + 1'b1)));

  // R3: a fresh heartbeat request only while beaconing
  a_r3_hb_when_locked: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(msgReq) && msgKind == KIND_HEARTBEAT) |-> $past(strb.hbRun));

  // R7: no heartbeat stays queued once beaconing stops
  a_r7_no_pend_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.hbRun |=> !hbPend);

endmodule

// File: rtl/hb_lockup_sched.sv
module hb_lockup_sched
  import hbsched_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 100_000_000,
  parameter int unsigned HB_SECONDS    = 31,
  parameter int unsigned SEQ_W         = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wdtExpire,
  input  logic             hwEvent,
  input  logic             stsClear,
  input  logic             pwrWorking,
  input  logic             msgAck,
  output logic             msgReq,
  output logic [SEQ_W-1:0] msgSeq,
  output logic             msgKind,
  output logic             rebootReq,
  output logic             lockupSts
);

  ctrlStrobe_t strb;
  msgKind_e    kindQ;

  hbs_recovery_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wdtExpire  (wdtExpire),
    .hwEvent    (hwEvent),
    .stsClear   (stsClear),
    .pwrWorking (pwrWorking),
    .strb       (strb),
    .rebootReq  (rebootReq),
    .lockupSts  (lockupSts)
  );

  hbs_msg_path #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .HB_SECONDS    (HB_SECONDS),
    .SEQ_W         (SEQ_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .msgAck  (msgAck),
    .msgReq  (msgReq),
    .msgSeq  (msgSeq),
    .msgKind (kindQ)
  );

  assign msgKind = kindQ;

endmodule

// File: tb/tb_hb_lockup_sched.sv
module tb_hb_lockup_sched;

  localparam int TPS    = 4;
  localparam int HBS    = 3;
  localparam int PERIOD = TPS * HBS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wdtExpire = 1'b0;
  logic       hwEvent = 1'b0;
  logic       stsClear = 1'b0;
  logic       pwrWorking = 1'b1;
  logic       ackEn = 1'b1;
  logic       msgAck;
  logic       msgReq;
  logic [3:0] msgSeq;
  logic       msgKind;
  logic       rebootReq;
  logic       lockupSts;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int nEvt = 0, nHb = 0, nReboot = 0;
  int lastEvtCyc = -1, lastHbCyc = -1, prevHbCyc = -1;
  int lastKind = -1, lastSeq = -1, lastHbSeq = -1;
  int expSeq = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign msgAck = ackEn && msgReq;

  hb_lockup_sched #(.TICKS_PER_SEC(TPS), .HB_SECONDS(HBS), .SEQ_W(4)) dut (
    .clk(clk), .rstN(rstN), .wdtExpire(wdtExpire), .hwEvent(hwEvent),
    .stsClear(stsClear), .pwrWorking(pwrWorking), .msgAck(msgAck),
    .msgReq(msgReq), .msgSeq(msgSeq), .msgKind(msgKind),
    .rebootReq(rebootReq), .lockupSts(lockupSts)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: log every accepted message and every reboot pulse
  always @(negedge clk) begin
    if (rstN && msgReq && msgAck) begin
      lastKind = int'(msgKind);
      lastSeq  = int'(msgSeq);
      if (msgKind) begin
        nEvt++;
        lastEvtCyc = cyc;
      end else begin
        nHb++;
        prevHbCyc = lastHbCyc;
        lastHbCyc = cyc;
        lastHbSeq = int'(msgSeq);
      end
    end
    if (rstN && rebootReq) nReboot++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic evtPulse();
    @(negedge clk); hwEvent = 1'b1;
    @(negedge clk); hwEvent = 1'b0;
  endtask

  // returns the edge number at which the pulse was sampled
  task automatic wdtPulse(output int edgeAt);
    @(negedge clk); wdtExpire = 1'b1;
    @(negedge clk); wdtExpire = 1'b0; edgeAt = cyc;
  endtask

  task automatic clrPulse();
    @(negedge clk); stsClear = 1'b1;
    @(negedge clk); stsClear = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int k, n0, n1, L;
    waitCyc(5);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!msgReq, "R1 msgReq", int'(msgReq), 0);
    check(!rebootReq, "R1 rebootReq", int'(rebootReq), 0);
    check(!lockupSts, "R1 lockupSts", int'(lockupSts), 0);

    // R2 event sequence and wrap (R1: first event carries 1)
    for (int i = 0; i < 17; i++) begin
      evtPulse();
      waitCyc(3);
      expSeq = (expSeq + 1) % 16;
      check(lastKind == 1 && lastSeq == expSeq, "R2 event seq", lastSeq, expSeq);
    end
    check(nEvt == 17, "R2 event count", nEvt, 17);

    // R9 held request while not acknowledged
    ackEn = 1'b0;
    evtPulse();
    waitCyc(1);
    expSeq = (expSeq + 1) % 16;
    check(msgReq && msgKind && int'(msgSeq) == expSeq, "R9 req raised", int'(msgSeq), expSeq);
    waitCyc(6);
    check(msgReq && msgKind && int'(msgSeq) == expSeq, "R9 req held", int'(msgSeq), expSeq);
    ackEn = 1'b1;
    waitCyc(2);
    check(!msgReq && nEvt == 18, "R9 released", nEvt, 18);

    // R3 no heartbeat while status is clear
    waitCyc(40);
    check(nHb == 0, "R3 no hb idle", nHb, 0);

    // R6 watchdog ignored outside working state
    pwrWorking = 1'b0;
    wdtPulse(k);
    waitCyc(3);
    check(!lockupSts && nReboot == 0 && nEvt == 18, "R6 wdt ignored", nReboot, 0);
    pwrWorking = 1'b1;

    // R4 first lockup
    wdtPulse(k);
    check(lockupSts && rebootReq, "R4 sts+reboot", int'(lockupSts) + int'(rebootReq), 2);
    waitCyc(1);
    check(!rebootReq, "R4 reboot one cycle", int'(rebootReq), 0);
    waitCyc(2);
    expSeq = (expSeq + 1) % 16;
    check(nEvt == 19 && lastSeq == expSeq && lastEvtCyc == k + 1, "R4 one event", lastEvtCyc, k + 1);
    check(nReboot == 1, "R4 reboot count", nReboot, 1);

    // R3 heartbeat timing and sequence
    waitUntil(k + PERIOD + 2);
    check(lastHbCyc == k + PERIOD + 1, "R3 first hb time", lastHbCyc, k + PERIOD + 1);
    check(lastHbSeq == expSeq, "R3 hb seq", lastHbSeq, expSeq);
    waitUntil(k + 2 * PERIOD + 2);
    check(lastHbCyc - prevHbCyc == PERIOD, "R3 hb interval", lastHbCyc - prevHbCyc, PERIOD);
    check(lastHbSeq == expSeq && nEvt == 19, "R3 hb seq steady", lastHbSeq, expSeq);

    // R5 second and third expiry
    n0 = nHb;
    wdtPulse(k);
    waitCyc(2);
    wdtPulse(k);
    waitCyc(2);
    wdtPulse(k);
    waitCyc(30);
    check(nReboot == 1, "R5 no reboot", nReboot, 1);
    check(nEvt == 19 && lockupSts, "R5 no event", nEvt, 19);
    check(nHb >= n0 + 2, "R5 hb continue", nHb, n0 + 2);

    // R8 event coinciding with heartbeat due edge
    n0 = nHb;
    while (nHb == n0) @(negedge clk);
    L = lastHbCyc;
    n1 = nHb;
    waitUntil(L + PERIOD - 2);
    hwEvent = 1'b1;
    @(negedge clk); hwEvent = 1'b0;
    expSeq = (expSeq + 1) % 16;
    waitUntil(L + PERIOD + 6);
    check(nHb == n1, "R8 hb dropped", nHb, n1);
    check(lastEvtCyc == L + PERIOD && lastSeq == expSeq, "R8 event wins", lastEvtCyc, L + PERIOD);
    waitUntil(L + 2 * PERIOD + 2);
    check(lastHbCyc == L + 2 * PERIOD, "R8 hb restart", lastHbCyc, L + 2 * PERIOD);

    // R6 soft-off: clear ignored, beacons continue
    pwrWorking = 1'b0;
    clrPulse();
    wdtPulse(k);
    waitCyc(2);
    check(lockupSts && nReboot == 1, "R6 clear ignored", int'(lockupSts), 1);
    n0 = nHb;
    waitCyc(30);
    check(nHb >= n0 + 2, "R6 hb in soft-off", nHb, n0 + 2);
    pwrWorking = 1'b1;

    // R7 firmware clear
    clrPulse();
    check(!lockupSts, "R7 sts cleared", int'(lockupSts), 0);
    waitCyc(2);
    n0 = nHb;
    waitCyc(40);
    check(nHb == n0, "R7 hb stopped", nHb, n0);
    wdtPulse(k);
    check(lockupSts && rebootReq, "R7 relock reboot", int'(rebootReq), 1);
    waitCyc(3);
    check(nReboot == 2, "R7 reboot count", nReboot, 2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule